// File: doc/BRIEF.md
# Alarm-Driven Power Sequencer

This block decides whether an external power regulator stays enabled. It holds a second, full-date alarm (seconds through years, all BCD) and compares it with the calendar time supplied from outside. The comparison is made only on the one-cycle strobe that marks a seconds update. When the alarm matches, a sticky status flag is raised, and an interrupt follows if its enable is set. If power control is armed in the control word and the interrupt is enabled, the same match drives the power-enable output low. The output then stays low until a wake pin brings it back.

Four external wake pins can restore power while it is off. Each pin has its own enable bit and its own polarity bit in the control word. Firmware arms a power-down by loading the alarm at least two seconds ahead of the current time, setting the power-control bit and enabling the interrupt. This leaves time to finish the writes before the next seconds update. Debouncing of the wake pins and the calendar counter itself are outside this block.

Top module: `pmic_pwr_seq`

## Requirements
- R1: After a synchronous reset, `pmic_power_en` is 1 and `alarm2_status` and `alarm2_irq` are 0. The control word is cleared, so a match does not remove power until bit 16 is written.
- R2: Alarm fields are written one byte each at `cfg_addr` 0x80 (seconds), 0x84 (minutes), 0x88 (hours), 0x8C (day), 0x90 (month) and 0x94 (year), using `cfg_wdata[7:0]`. `cur_time` packs seconds in [7:0], minutes in [15:8], hours in [23:16], day in [31:24], month in [39:32] and year in [47:40]. A match needs all six bytes equal.
- R3: A match is evaluated only in a cycle where `sec_tick` is 1. An equal time held without the strobe never sets status or removes power, so the alarm fires at most once per seconds update.
- R4: A match sets `alarm2_status` at the next clock edge. A `status_clr` pulse clears it. If a match and a clear fall in the same cycle, the match wins.
- R5: `alarm2_irq` equals `alarm2_status` gated by `alarm_irq_en`, registered so that it updates on the same edge as the status.
- R6: The control word is written in full at `cfg_addr` 0x98. If bit 16 is 1 and `alarm_irq_en` is 1 at a match, `pmic_power_en` goes to 0 at the next edge and stays 0 while no wake pin is active. If either condition is missing, the power stays on, although the status still sets.
- R7: While power is off, a wake pin i brings `pmic_power_en` back to 1 at the next edge when its enable bit i (bits 0 to 3) is set and its level is active. Polarity bit 4+i set to 1 makes the pin active-low; 0 makes it active-high. Disabled pins and inactive levels have no effect.
- R8: A write to any address other than 0x98 leaves the control word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration write address |
| cfg_wdata | input | 32 | Configuration write data |
| sec_tick | input | 1 | One-cycle strobe marking a seconds update |
| cur_time | input | 48 | Current BCD date and time |
| alarm_irq_en | input | 1 | Alarm interrupt enable |
| status_clr | input | 1 | Clear strobe for the alarm status |
| ext_wake | input | 4 | External wake pin levels |
| pmic_power_en | output | 1 | Regulator enable, 1 = power on |
| alarm2_status | output | 1 | Sticky alarm flag |
| alarm2_irq | output | 1 | Alarm interrupt |

## Verification
Setting the status from a match and clearing it from software can land on the same clock edge. The bench first clears the flag. It then raises `status_clr` in the very cycle that carries a matching `sec_tick`, and expects the flag to read 1 afterwards. A match can also arrive while power is already off and a wake pin is active, but the power path decides this by its current state. That case is covered by the power-off and wake scenarios, which exercise each transition separately.

// File: rtl/pmic_seq_pkg.sv
package pmic_seq_pkg;
  localparam int FIELD_W      = 8;
  localparam int NUM_FIELDS   = 6;
  localparam int ADDR_W       = 8;
  localparam int DATA_W       = 32;
  localparam int NUM_WAKE     = 4;
  localparam int PWR_CTL_BIT  = 16;
  localparam int WAKE_POL_LSB = 4;
  localparam int ALM_BASE     = 'h80;
  localparam int ALM_STRIDE   = 4;
  localparam int CTRL_ADDR    = 'h98;
endpackage

// File: rtl/pmic_alarm_cmp.sv
module pmic_alarm_cmp #(
  parameter int FIELD_W    = pmic_seq_pkg::FIELD_W,
  parameter int NUM_FIELDS = pmic_seq_pkg::NUM_FIELDS,
  parameter int ADDR_W     = pmic_seq_pkg::ADDR_W,
  parameter int BASE       = pmic_seq_pkg::ALM_BASE,
  parameter int STRIDE     = pmic_seq_pkg::ALM_STRIDE
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cfg_we,
  input  logic [ADDR_W-1:0]             cfg_addr,
  input  logic [FIELD_W-1:0]            cfg_byte,
  input  logic                          sec_tick,
  input  logic [NUM_FIELDS*FIELD_W-1:0] cur_time,
  output logic                          match
);
  logic [NUM_FIELDS-1:0] field_eq;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    localparam logic [ADDR_W-1:0] FIELD_ADDR = ADDR_W'(BASE + STRIDE * i);
    logic [FIELD_W-1:0] alm_q;

    always_ff @(posedge clk) begin
      if (rst)
        alm_q <= '0;
      else if (cfg_we && cfg_addr == FIELD_ADDR)
        alm_q <= cfg_byte;
    end

    assign field_eq[i] = (cur_time[i*FIELD_W +: FIELD_W] == alm_q);
  end

  // R3: compared only on the seconds strobe
  assign match = sec_tick & (&field_eq);
endmodule

// File: rtl/pmic_wake_detect.sv
module pmic_wake_detect #(
  parameter int NUM_WAKE = pmic_seq_pkg::NUM_WAKE
) (
  input  logic [NUM_WAKE-1:0] pin_lvl,
  input  logic [NUM_WAKE-1:0] pin_en,
  input  logic [NUM_WAKE-1:0] pin_low_act,
  output logic                wake_any
);
  logic [NUM_WAKE-1:0] hit;

  for (genvar i = 0; i < NUM_WAKE; i++) begin : g_pin
    // R7: the polarity bit inverts the sense of the pin
    assign hit[i] = pin_en[i] & (pin_lvl[i] ^ pin_low_act[i]);
  end

  assign wake_any = |hit;
endmodule

// File: rtl/pmic_pwr_ctrl.sv
module pmic_pwr_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic off_req,
  input  logic wake_any,
  output logic pwr_en
);
  always_ff @(posedge clk) begin
    if (rst)
      pwr_en <= 1'b1;
    else if (pwr_en && off_req)
      pwr_en <= 1'b0;
    else if (!pwr_en && wake_any)
      pwr_en <= 1'b1;
  end

  assert_pwr_off_R6: assert property (@(posedge clk) disable iff (rst)
    (pwr_en && off_req) |=> !pwr_en);
  assert_pwr_hold_off_R6: assert property (@(posedge clk) disable iff (rst)
    (!pwr_en && !wake_any) |=> !pwr_en);
  assert_pwr_hold_on_R6: assert property (@(posedge clk) disable iff (rst)
    (pwr_en && !off_req) |=> pwr_en);
  assert_wake_on_R7: assert property (@(posedge clk) disable iff (rst)
    (!pwr_en && wake_any) |=> pwr_en);
endmodule

// File: rtl/pmic_pwr_seq.sv
module pmic_pwr_seq
  import pmic_seq_pkg::*;
#(
  parameter int P_FIELD_W    = FIELD_W,
  parameter int P_NUM_FIELDS = NUM_FIELDS,
  parameter int P_ADDR_W     = ADDR_W,
  parameter int P_DATA_W     = DATA_W,
  parameter int P_NUM_WAKE   = NUM_WAKE
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              cfg_we,
  input  logic [P_ADDR_W-1:0]               cfg_addr,
  input  logic [P_DATA_W-1:0]               cfg_wdata,
  input  logic                              sec_tick,
  input  logic [P_NUM_FIELDS*P_FIELD_W-1:0] cur_time,
  input  logic                              alarm_irq_en,
  input  logic                              status_clr,
  input  logic [P_NUM_WAKE-1:0]             ext_wake,
  output logic                              pmic_power_en,
  output logic                              alarm2_status,
  output logic                              alarm2_irq
);
  localparam logic [P_ADDR_W-1:0] CTRL_A = P_ADDR_W'(CTRL_ADDR);

  logic [P_DATA_W-1:0] ctrl_q;
  logic                match;
  logic                wake_any;
  logic                off_req;
  logic                status_n;

  // R8: only the control address updates the control word
  always_ff @(posedge clk) begin
    if (rst)
      ctrl_q <= '0;
    else if (cfg_we && cfg_addr == CTRL_A)
      ctrl_q <= cfg_wdata;
  end

  pmic_alarm_cmp #(
    .FIELD_W   (P_FIELD_W),
    .NUM_FIELDS(P_NUM_FIELDS),
    .ADDR_W    (P_ADDR_W)
  ) u_cmp (
    .clk     (clk),
    .rst     (rst),
    .cfg_we  (cfg_we),
    .cfg_addr(cfg_addr),
    .cfg_byte(cfg_wdata[P_FIELD_W-1:0]),
    .sec_tick(sec_tick),
    .cur_time(cur_time),
    .match   (match)
  );

  pmic_wake_detect #(.NUM_WAKE(P_NUM_WAKE)) u_wake (
    .pin_lvl    (ext_wake),
    .pin_en     (ctrl_q[P_NUM_WAKE-1:0]),
    .pin_low_act(ctrl_q[WAKE_POL_LSB +: P_NUM_WAKE]),
    .wake_any   (wake_any)
  );

  assign off_req = match & ctrl_q[PWR_CTL_BIT] & alarm_irq_en;

  pmic_pwr_ctrl u_pwr (
    .clk     (clk),
    .rst     (rst),
    .off_req (off_req),
    .wake_any(wake_any),
    .pwr_en  (pmic_power_en)
  );

  // R4: a set outranks a clear in the same cycle
  assign status_n = match | (alarm2_status & ~status_clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      alarm2_status <= 1'b0;
      alarm2_irq    <= 1'b0;
    end else begin
      alarm2_status <= status_n;
      alarm2_irq    <= status_n & alarm_irq_en;
    end
  end

  assert_status_set_R4: assert property (@(posedge clk) disable iff (rst)
    match |=> alarm2_status);
  assert_status_clr_R4: assert property (@(posedge clk) disable iff (rst)
    (alarm2_status && status_clr && !match) |=> !alarm2_status);
  assert_irq_needs_status_R5: assert property (@(posedge clk) disable iff (rst)
    alarm2_irq |-> alarm2_status);
endmodule

// File: tb/pmic_pwr_seq_tb.sv
module pmic_pwr_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [47:0] T_ALM = 48'h25_06_15_23_59_58;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        sec_tick = 1'b0;
  logic [47:0] cur_time = '0;
  logic        alarm_irq_en = 1'b0;
  logic        status_clr = 1'b0;
  logic [3:0]  ext_wake = '0;
  logic        pmic_power_en, alarm2_status, alarm2_irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pmic_pwr_seq u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .sec_tick(sec_tick), .cur_time(cur_time),
    .alarm_irq_en(alarm_irq_en), .status_clr(status_clr), .ext_wake(ext_wake),
    .pmic_power_en(pmic_power_en), .alarm2_status(alarm2_status),
    .alarm2_irq(alarm2_irq)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic tick(input logic [47:0] t);
    @(negedge clk);
    cur_time = t; sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
  endtask

  task automatic clear_status();
    @(negedge clk);
    status_clr = 1'b1;
    @(negedge clk);
    status_clr = 1'b0;
  endtask

  task automatic t_reset();
    check("R1", "power after reset", pmic_power_en, 1'b1);
    check("R1", "status after reset", alarm2_status, 1'b0);
    check("R1", "irq after reset", alarm2_irq, 1'b0);
  endtask

  task automatic t_program_alarm();
    for (int i = 0; i < 6; i++) wr(8'h80 + 8'(4*i), {24'h0, T_ALM[8*i +: 8]});
  endtask

  task automatic t_default_ctrl_r1();
    alarm_irq_en = 1'b1;
    tick(T_ALM);
    check("R1", "power kept with cleared control word", pmic_power_en, 1'b1);
    check("R4", "status set by match", alarm2_status, 1'b1);
    clear_status();
  endtask

  task automatic t_no_tick_r3();
    wr(8'h98, 32'h0001_0000);
    @(negedge clk);
    cur_time = T_ALM;
    repeat (4) @(negedge clk);
    check("R3", "status without strobe", alarm2_status, 1'b0);
    check("R3", "power without strobe", pmic_power_en, 1'b1);
    wr(8'h98, 32'h0);
  endtask

  task automatic t_fields_r2();
    for (int i = 0; i < 6; i++) begin
      logic [47:0] t = T_ALM;
      t[8*i +: 8] = t[8*i +: 8] ^ 8'h01;
      tick(t);
      check("R2", $sformatf("status with field %0d off", i), alarm2_status, 1'b0);
    end
    tick(T_ALM);
    check("R2", "status on full match", alarm2_status, 1'b1);
    check("R5", "irq with enable", alarm2_irq, 1'b1);
  endtask

  task automatic t_clear_r4();
    clear_status();
    check("R4", "status after clear", alarm2_status, 1'b0);
    check("R5", "irq after clear", alarm2_irq, 1'b0);
    @(negedge clk);
    cur_time = T_ALM; sec_tick = 1'b1; status_clr = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0; status_clr = 1'b0;
    check("R4", "set wins over clear", alarm2_status, 1'b1);
    clear_status();
  endtask

  task automatic t_irq_mask_r5();
    alarm_irq_en = 1'b0;
    tick(T_ALM);
    check("R5", "status with irq masked", alarm2_status, 1'b1);
    check("R5", "irq masked", alarm2_irq, 1'b0);
    @(negedge clk);
    alarm_irq_en = 1'b1;
    @(negedge clk);
    check("R5", "irq after enable", alarm2_irq, 1'b1);
    clear_status();
  endtask

  task automatic t_no_off_r6();
    wr(8'h98, 32'h0000_0005);
    tick(T_ALM);
    check("R6", "power with bit16 clear", pmic_power_en, 1'b1);
    wr(8'h98, 32'h0001_0000);
    alarm_irq_en = 1'b0;
    tick(T_ALM);
    check("R6", "power with irq disabled", pmic_power_en, 1'b1);
    alarm_irq_en = 1'b1;
    wr(8'h98, 32'h0);
    wr(8'h9C, 32'h0001_0000);
    tick(T_ALM);
    check("R8", "power after write to other address", pmic_power_en, 1'b1);
    clear_status();
  endtask

  task automatic t_off_wake_r7();
    ext_wake = 4'b0100;
    wr(8'h98, 32'h0001_0045);
    tick(T_ALM);
    check("R6", "power off on armed match", pmic_power_en, 1'b0);
    repeat (5) @(negedge clk);
    check("R6", "power stays off", pmic_power_en, 1'b0);
    ext_wake = 4'b1110;
    repeat (2) @(negedge clk);
    check("R7", "disabled pins ignored", pmic_power_en, 1'b0);
    ext_wake = 4'b0000;
    @(negedge clk);
    @(negedge clk);
    check("R7", "active-low pin wakes", pmic_power_en, 1'b1);
    ext_wake = 4'b0100;
    tick(T_ALM);
    check("R6", "power off again", pmic_power_en, 1'b0);
    ext_wake = 4'b0101;
    @(negedge clk);
    @(negedge clk);
    check("R7", "active-high pin wakes", pmic_power_en, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_program_alarm();
    t_default_ctrl_r1();
    t_no_tick_r3();
    t_fields_r2();
    t_clear_r4();
    t_irq_mask_r5();
    t_no_off_r6();
    t_off_wake_r7();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule